// File: doc/BRIEF.md
# Strobe-Driven FIFO with Rewind and Half-Level Flag

This block is a single-clock first-in/first-out buffer for 9-bit words. Its depth is a parameter that takes one of 256, 512, 1024, 2048, 4096 or 8192. The producer and the consumer each drive an active-low strobe. The block registers both strobes and acts on each falling edge it sees. A write is taken only while the buffer has room. A read is taken only while the buffer holds data. The output enable goes high when a read is accepted and stays high until the read strobe is released. A low output enable stands for a released, high-impedance output.

Three registered active-low flags report the fill state: empty, full, and more than half full. An active-low rewind strobe sends the read pointer back to storage location zero and leaves the write pointer where it is. The stored words can then be read a second time, and the flags are recomputed from the new pointer distance. A rewind is honoured only while the read and write strobes are both idle. Its purpose is to replay data when fewer than DEPTH words have been written since the last reset.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers go to location 0, and after that edge `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0. No write is taken before the first reset.
- R2: A falling edge on `wr_n` while not full stores `din` and advances the write pointer. A falling edge on `rd_n` while not empty puts the oldest stored word on `dout` with `dout_oe`=1. Words come out in the order they went in. Both outputs are valid by the second rising clock edge after the strobe falls.
- R3: `full_n` goes low when the occupancy reaches DEPTH, which takes exactly DEPTH writes after reset with no reads. While the buffer is full, write strobes change neither the stored data nor the occupancy.
- R4: `empty_n` is low exactly when the occupancy is zero. While the buffer is empty, read strobes leave `dout_oe` at 0 and change no stored state.
- R5: `half_n` is low exactly when the occupancy exceeds DEPTH/2. It falls on the write that crosses DEPTH/2 and rises on the read that brings the occupancy back to DEPTH/2.
- R6: A falling edge on `rt_n` while `wr_n` and `rd_n` are both idle (high) sets the read pointer to location 0 and sets the occupancy to the write pointer value. The write pointer is not changed, and all three flags follow the new occupancy.
- R7: A falling edge on `rt_n` while either `wr_n` or `rd_n` is low is ignored.
- R8: A read and a write taken at the same clock edge leave the occupancy, and so all three flags, unchanged.
- R9: `dout_oe` returns to 0 by the second rising clock edge after `rd_n` goes high, and it stays 0 while `rd_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low, acts on its falling edge |
| rd_n | input | 1 | Read strobe, active low, acts on its falling edge |
| rt_n | input | 1 | Rewind strobe, active low, acts on its falling edge |
| din | input | 9 | Word to store |
| dout | output | 9 | Word read out |
| dout_oe | output | 1 | High while a read is driving `dout` |
| empty_n | output | 1 | Low when the buffer is empty |
| full_n | output | 1 | Low when the buffer is full |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |

## Verification
The assertions assume three things about the inputs. `wr_n`, `rd_n` and `rt_n` are synchronous to `clk`. Each low or high level lasts at least two cycles, so that every falling edge is seen. A rewind is requested only when fewer than DEPTH words have been written since reset. The stimulus drives every strobe level for at least two cycles and holds `din` steady across each write. It applies rewinds only in directed sequences that start from a fresh reset and write only a few words. The random phase uses only writes, reads and combined operations, so it stays within the range where occupancy is defined.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic active,
  output logic fall
);
  logic lvl_q1, lvl_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q1 <= 1'b1;
      lvl_q2 <= 1'b1;
    end else begin
      lvl_q1 <= strobe_n;
      lvl_q2 <= lvl_q1;
    end
  end

  assign active = ~lvl_q1;
  assign fall   = lvl_q2 & ~lvl_q1;
endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    act,      // {rewind, read, write} strobe levels, 1 = active
  input  logic          wr_fall,
  input  logic          rd_fall,
  input  logic          rt_fall,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic          armed = 1'b0;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_nxt;
  logic          wr_acc, rd_acc, rt_acc;

  assign wr_acc = armed & wr_fall & (count != FULL_CNT);
  assign rd_acc = armed & rd_fall & (count != '0);
  assign rt_acc = armed & rt_fall & (act == 3'b100);

  always_comb begin
    count_nxt = count;
    if (rt_acc) begin
      count_nxt = {1'b0, wr_ptr};
    end else begin
      case ({wr_acc, rd_acc})
        2'b10:   count_nxt = count + 1'b1;
        2'b01:   count_nxt = count - 1'b1;
        default: count_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b1;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      empty_n <= 1'b0;
      full_n  <= 1'b1;
      half_n  <= 1'b1;
    end else if (armed) begin
      if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
      if (rt_acc) rd_ptr <= '0;
      else if (rd_acc) rd_ptr <= rd_ptr + 1'b1;
      count   <= count_nxt;
      empty_n <= (count_nxt != '0);
      full_n  <= (count_nxt != FULL_CNT);
      half_n  <= (count_nxt <= HALF_CNT);
    end
  end

  assign wr_en   = wr_acc;
  assign wr_addr = wr_ptr;
  assign rd_en   = rd_acc;
  assign rd_addr = rd_ptr;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    count <= FULL_CNT);
  // R3
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (!full_n && wr_fall && !rd_fall) |=> ($stable(wr_ptr) && $stable(count)));
  // R4
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (!empty_n && rd_fall && !wr_fall) |=> ($stable(rd_ptr) && $stable(count)));
  // R4
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    empty_n == (count != '0));
  // R5
  half_flag_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    half_n == (count <= HALF_CNT));
  // R6
  rewind_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    rt_acc |=> (rd_ptr == '0 && $stable(wr_ptr)));
  // R7
  rewind_blocked_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (rt_fall && act[0] && !rd_fall) |=> $stable(rd_ptr));
  // R8
  both_ops_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (wr_acc && rd_acc) |=> $stable(count));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int unsigned DEPTH = 256
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_n,
  input  logic                         rd_n,
  input  logic                         rt_n,
  input  logic [sfifo_pkg::WORD_W-1:0] din,
  output logic [sfifo_pkg::WORD_W-1:0] dout,
  output logic                         dout_oe,
  output logic                         empty_n,
  output logic                         full_n,
  output logic                         half_n
);
  import sfifo_pkg::*;
  localparam int unsigned AW = $clog2(DEPTH);

  logic [2:0]    strobes_n, act, fall;
  word_t         din_q;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  assign strobes_n = {rt_n, rd_n, wr_n};

  for (genvar g = 0; g < 3; g++) begin : g_strobe
    strobe_edge u_edge (
      .clk      (clk),
      .rst      (rst),
      .strobe_n (strobes_n[g]),
      .active   (act[g]),
      .fall     (fall[g])
    );
  end

  always_ff @(posedge clk) din_q <= din;

  sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .wr_fall (fall[0]),
    .rd_fall (fall[1]),
    .rt_fall (fall[2]),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
  );

  sfifo_ram #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (din_q),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (dout)
  );

  always_ff @(posedge clk) begin
    if (rst)         dout_oe <= 1'b0;
    else if (rd_en)  dout_oe <= 1'b1;
    else if (!act[1]) dout_oe <= 1'b0;
  end

  // R9
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    !act[1] |=> !dout_oe);
  // R2
  oe_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> dout_oe);
endmodule

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;
  localparam int unsigned DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       dout_oe, empty_n, full_n, half_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int unsigned m_mem [DEPTH];
  int unsigned m_wp, m_rp, m_cnt;

  always #5 clk = ~clk;

  strobe_fifo #(.DEPTH(DEPTH)) i_strobe_fifo (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act_v, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  function automatic bit exp_empty_n(); return m_cnt != 0; endfunction
  function automatic bit exp_full_n();  return m_cnt != DEPTH; endfunction
  function automatic bit exp_half_n();  return m_cnt <= DEPTH / 2; endfunction

  task automatic check_flags(input string tag);
    chk(empty_n == exp_empty_n(), {"R4 ", tag}, "empty_n", int'(empty_n), int'(exp_empty_n()));
    chk(full_n == exp_full_n(), {"R3 ", tag}, "full_n", int'(full_n), int'(exp_full_n()));
    chk(half_n == exp_half_n(), {"R5 ", tag}, "half_n", int'(half_n), int'(exp_half_n()));
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_wp = 0; m_rp = 0; m_cnt = 0;
    repeat (2) @(negedge clk);
  endtask

  // One strobe cycle: write, read, or both together.
  task automatic do_op(input bit w, input bit r, input logic [8:0] d, input string tag);
    bit w_ok, r_ok;
    int unsigned exp_d;
    w_ok  = w && (m_cnt < DEPTH);
    r_ok  = r && (m_cnt > 0);
    exp_d = m_mem[m_rp];
    @(negedge clk);
    din = d; wr_n = !w; rd_n = !r;
    repeat (2) @(negedge clk);
    if (r) begin
      chk(dout_oe == r_ok, r_ok ? "R2" : "R4", {tag, " dout_oe during read"},
          int'(dout_oe), int'(r_ok));
      if (r_ok) chk(dout == exp_d[8:0], "R2", {tag, " read data"}, int'(dout), int'(exp_d));
    end
    if (w_ok) begin m_mem[m_wp] = int'(d); m_wp = (m_wp + 1) % DEPTH; end
    if (r_ok) m_rp = (m_rp + 1) % DEPTH;
    if (w_ok && !r_ok) m_cnt++;
    if (r_ok && !w_ok) m_cnt--;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout_oe == 1'b0, "R9", {tag, " dout_oe after release"}, int'(dout_oe), 0);
    check_flags(tag);
  endtask

  task automatic do_rewind();
    @(negedge clk);
    rt_n = 1'b0;
    repeat (2) @(negedge clk);
    rt_n = 1'b1;
    repeat (3) @(negedge clk);
    m_rp = 0;
    m_cnt = m_wp;
    check_flags("R6 rewind");
  endtask

  initial begin
    int unsigned seed;
    int unsigned sel;
    seed = $urandom(32'h5EED);

    // R1 reset state
    do_reset();
    chk(empty_n == 1'b0, "R1", "empty_n after reset", int'(empty_n), 0);
    chk(full_n == 1'b1, "R1", "full_n after reset", int'(full_n), 1);
    chk(half_n == 1'b1, "R1", "half_n after reset", int'(half_n), 1);
    chk(dout_oe == 1'b0, "R1", "dout_oe after reset", int'(dout_oe), 0);

    // R4: read while empty is ignored
    do_op(1'b0, 1'b1, 9'h000, "R4 empty read");
    // R2: order of delivery
    do_op(1'b1, 1'b0, 9'h1A5, "R2 w");
    do_op(1'b1, 1'b0, 9'h05A, "R2 w");
    do_op(1'b1, 1'b0, 9'h100, "R2 w");
    do_op(1'b0, 1'b1, 9'h000, "R2 r");
    // R8: read and write together
    do_op(1'b1, 1'b1, 9'h0C3, "R8 both");
    do_op(1'b1, 1'b1, 9'h13C, "R8 both");
    do_op(1'b0, 1'b1, 9'h000, "R2 r");
    do_op(1'b0, 1'b1, 9'h000, "R2 r");
    do_op(1'b0, 1'b1, 9'h000, "R2 r");
    // R8 with empty buffer: only the write is taken
    do_op(1'b1, 1'b1, 9'h0EE, "R8 both empty");
    do_op(1'b0, 1'b1, 9'h000, "R2 r");

    // R6: rewind replays from location 0
    do_reset();
    for (int i = 0; i < 6; i++) do_op(1'b1, 1'b0, 9'(9'h040 + i), "R6 fill");
    for (int i = 0; i < 4; i++) do_op(1'b0, 1'b1, 9'h000, "R6 pre-read");
    do_rewind();
    for (int i = 0; i < 7; i++) do_op(1'b0, 1'b1, 9'h000, "R6 replay");

    // R7: rewind ignored while the read strobe is low
    do_reset();
    for (int i = 0; i < 4; i++) do_op(1'b1, 1'b0, 9'(9'h080 + i), "R7 fill");
    @(negedge clk);
    rd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(dout == 9'h080, "R7", "read under held strobe", int'(dout), 'h080);
    m_rp = 1; m_cnt = 3;
    rt_n = 1'b0;
    repeat (3) @(negedge clk);
    rt_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check_flags("R7 after blocked rewind");
    do_op(1'b0, 1'b1, 9'h000, "R7 next word");
    chk(dout == 9'h081, "R7", "word after blocked rewind", int'(dout), 'h081);

    // R3 / R5: fill to full, overfill, drain, overdrain
    do_reset();
    for (int i = 0; i < DEPTH; i++) do_op(1'b1, 1'b0, 9'(i * 7 + 3), "R3 fill");
    chk(full_n == 1'b0, "R3", "full after DEPTH writes", int'(full_n), 0);
    do_op(1'b1, 1'b0, 9'h1FF, "R3 write when full");
    do_op(1'b1, 1'b0, 9'h1FE, "R3 write when full");
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH / 2 - 1)
        chk(half_n == 1'b0, "R5", "half_n at DEPTH/2+1", int'(half_n), 0);
      do_op(1'b0, 1'b1, 9'h000, "R3 drain");
      if (i == DEPTH / 2 - 1)
        chk(half_n == 1'b1, "R5", "half_n at DEPTH/2", int'(half_n), 1);
    end
    do_op(1'b0, 1'b1, 9'h000, "R4 read when empty");

    // Random mix
    do_reset();
    for (int i = 0; i < 700; i++) begin
      sel = $urandom_range(0, 9);
      if (i % 200 < 120) begin
        if (sel < 6) do_op(1'b1, 1'b0, 9'($urandom), "R2 rnd");
        else if (sel < 8) do_op(1'b0, 1'b1, 9'h000, "R2 rnd");
        else do_op(1'b1, 1'b1, 9'($urandom), "R8 rnd");
      end else begin
        if (sel < 6) do_op(1'b0, 1'b1, 9'h000, "R2 rnd");
        else if (sel < 8) do_op(1'b1, 1'b0, 9'($urandom), "R2 rnd");
        else do_op(1'b1, 1'b1, 9'($urandom), "R8 rnd");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule